// File: doc/BRIEF.md
# Dual-Channel Transmit Packet Queue

This block is the transmit half of a simple Ethernet MAC. Software writes it through a 32-bit word-addressed register port. It holds two independent byte queues. A steering register picks which queue takes the 32-bit words written to a shared data address. Each word is split into four bytes, and the least significant byte goes first.

Each queue has its own length register and its own start command. A start is only accepted while the global transmit enable is set. The sender then streams the smaller of the programmed length and the number of bytes held out on a byte-wide valid/ready/last interface. When the frame ends, the sender empties that queue, zeroes its length and sets that queue's completion status bit. The interrupt line is high whenever an enabled status bit is set. Status bits are cleared by writing ones to them.

Register map (word addresses on `reg_addr` and `rd_addr`):

| Address | Register |
|---|---|
| 0 | control; bit 0 is transmit enable |
| 1 | queue select |
| 2 | data (write only) |
| 3 | length of queue 0 |
| 4 | length of queue 1 |
| 5 | start command for queue 0; bit 0 must be set |
| 6 | start command for queue 1; bit 0 must be set |
| 7 | interrupt enable; bits 1:0 |
| 8 | completion status; bits 1:0, written as write-one-to-clear |

Unused addresses read as zero.

Top module: `mac_txq_top`

## Requirements
- R1: A write to address 2 appends four bytes to the selected queue, bits 7:0 first and bits 31:24 last; they leave on `tx_data` in that order.
- R2: Writing the select register with a value of 0 or 1 stores it. Any value of 2 or more stores 0. The register reads back the stored value.
- R3: A data write is discarded when the selected queue has fewer than 4 free bytes; the queue contents are unchanged.
- R4: A length write above FIFO_BYTES stores FIFO_BYTES. Any other value is stored as written. The length register reads back the stored value.
- R5: A start write (bit 0 set) while control bit 0 is clear has no effect: nothing is streamed and the queue keeps its bytes.
- R6: An accepted start sends min(length, bytes held) bytes. If that count is 0, nothing is sent and the queue, the length and the status are left unchanged.
- R7: `tx_last` is high with the final byte of a frame only. In the cycle after that byte is accepted, `tx_valid` is low, the queue is empty, its length reads 0 and its status bit (bit 0 for queue 0, bit 1 for queue 1) is set.
- R8: `irq` equals the OR of (status AND enable). Writing address 8 clears each status bit written as 1; a completion in the same cycle wins.
- R9: A start for either queue that arrives while a frame is streaming is ignored.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: After reset, every readable register is 0, `tx_valid` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write word address |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Byte sink accepts the current byte |
| irq | output | 1 | Interrupt request |

## Verification
A register write is captured on the rising edge where `reg_we` is high. Its value shows on `rd_data` in the following cycle, so the bench drives on the falling edge and reads back one half-cycle after the capturing edge.

A start captured on edge k puts the first byte on `tx_valid` right after edge k. The completion status bit, the zeroed length and the change on `irq` all appear just after the edge that accepts the final byte.

The bench therefore samples the stream on every falling edge. It counts a byte only when `tx_valid` and `tx_ready` are both high at that instant, and it reads status and length once the last byte has been taken. For cases where nothing should happen, it watches `tx_valid` over a window of several cycles.

// File: rtl/mac_txq_pkg.sv
package mac_txq_pkg;

    localparam int NCH = 2;

    // register word addresses; lengths and starts are per-channel consecutive
    localparam logic [3:0] ADR_CTRL  = 4'd0;
    localparam logic [3:0] ADR_SEL   = 4'd1;
    localparam logic [3:0] ADR_DATA  = 4'd2;
    localparam logic [3:0] ADR_LEN0  = 4'd3;
    localparam logic [3:0] ADR_GO0   = 4'd5;
    localparam logic [3:0] ADR_IEN   = 4'd7;
    localparam logic [3:0] ADR_ISTAT = 4'd8;

    typedef enum logic {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;

endpackage

// File: rtl/mac_txq_fifo.sv
module mac_txq_fifo #(
    parameter  int FIFO_BYTES = 2048,
    localparam int PTR_W      = $clog2(FIFO_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [31:0]      push_word,
    input  logic             pop,
    output logic [7:0]       head_byte,
    output logic [PTR_W:0]   level,
    output logic             room4
);

    localparam int WORDS = FIFO_BYTES / 4;

    typedef struct packed {
        logic [PTR_W:0] wr;
        logic [PTR_W:0] rd;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [31:0] mem_q [WORDS];
    logic [31:0] head_word;

    assign level     = ptr_q.wr - ptr_q.rd;
    assign room4     = level <= (PTR_W + 1)'(FIFO_BYTES - 4);
    assign head_word = mem_q[ptr_q.rd[PTR_W-1:2]];
    assign head_byte = head_word[{ptr_q.rd[1:0], 3'b000} +: 8];

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            // write pointer only moves in steps of four, so it stays word aligned
            if (push && room4)
                ptr_d.wr = ptr_q.wr + (PTR_W + 1)'(4);
            if (pop && (level != '0))
                ptr_d.rd = ptr_q.rd + (PTR_W + 1)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (!clr && push && room4)
            mem_q[ptr_q.wr[PTR_W-1:2]] <= push_word;
    end

endmodule

// File: rtl/mac_txq_regs.sv
module mac_txq_regs
    import mac_txq_pkg::*;
#(
    parameter  int FIFO_BYTES = 2048,
    localparam int LEN_W      = $clog2(FIFO_BYTES) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [3:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    input  logic [3:0]                 rd_addr,
    input  logic [NCH-1:0]             done,
    output logic [31:0]                rd_data,
    output logic                       tx_en,
    output logic                       sel,
    output logic [NCH-1:0][LEN_W-1:0]  len,
    output logic [NCH-1:0]             ien,
    output logic [NCH-1:0]             istat,
    output logic                       data_push,
    output logic [NCH-1:0]             go
);

    typedef struct packed {
        logic                      en;
        logic                      sel;
        logic [NCH-1:0][LEN_W-1:0] len;
        logic [NCH-1:0]            ien;
        logic [NCH-1:0]            ist;
    } regs_t;

    regs_t r_q, r_d;
    logic [LEN_W-1:0] len_clamped;

    assign len_clamped = (reg_wdata > 32'(FIFO_BYTES)) ? LEN_W'(FIFO_BYTES)
                                                        : reg_wdata[LEN_W-1:0];

    always_comb begin
        r_d       = r_q;
        data_push = reg_we && (reg_addr == ADR_DATA);
        go        = '0;

        if (reg_we) begin
            case (reg_addr)
                ADR_CTRL: r_d.en  = reg_wdata[0];
                ADR_SEL:  r_d.sel = (reg_wdata < 32'(NCH)) ? reg_wdata[0] : 1'b0;
                ADR_IEN:  r_d.ien = reg_wdata[NCH-1:0];
                default:  ;
            endcase
        end

        for (int c = 0; c < NCH; c++) begin
            if (reg_we && (reg_addr == ADR_LEN0 + 4'(c)))
                r_d.len[c] = len_clamped;
            go[c] = reg_we && (reg_addr == ADR_GO0 + 4'(c)) && reg_wdata[0];
            if (done[c])
                r_d.len[c] = '0;
        end

        if (reg_we && (reg_addr == ADR_ISTAT))
            r_d.ist = r_q.ist & ~reg_wdata[NCH-1:0];
        r_d.ist = r_d.ist | done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL:  rd_data = {31'd0, r_q.en};
            ADR_SEL:   rd_data = {31'd0, r_q.sel};
            ADR_IEN:   rd_data = 32'(r_q.ien);
            ADR_ISTAT: rd_data = 32'(r_q.ist);
            default:   ;
        endcase
        for (int c = 0; c < NCH; c++)
            if (rd_addr == ADR_LEN0 + 4'(c))
                rd_data = 32'(r_q.len[c]);
    end

    assign tx_en = r_q.en;
    assign sel   = r_q.sel;
    assign len   = r_q.len;
    assign ien   = r_q.ien;
    assign istat = r_q.ist;

endmodule

// File: rtl/mac_txq_sender.sv
module mac_txq_sender
    import mac_txq_pkg::*;
#(
    parameter  int FIFO_BYTES = 2048,
    localparam int LEN_W      = $clog2(FIFO_BYTES) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic [NCH-1:0]             go,
    input  logic [NCH-1:0][LEN_W-1:0]  len,
    input  logic [NCH-1:0][LEN_W-1:0]  level,
    input  logic [NCH-1:0][7:0]        head,
    input  logic                       tx_ready,
    output logic                       tx_valid,
    output logic [7:0]                 tx_data,
    output logic                       tx_last,
    output logic [NCH-1:0]             pop,
    output logic [NCH-1:0]             done
);

    typedef struct packed {
        snd_state_e       st;
        logic             ch;
        logic [LEN_W-1:0] remain;
    } snd_t;

    snd_t s_q, s_d;
    logic [LEN_W-1:0] count;

    assign tx_valid = (s_q.st == SND_BUSY);
    assign tx_data  = head[s_q.ch];
    assign tx_last  = tx_valid && (s_q.remain == LEN_W'(1));

    always_comb begin
        s_d   = s_q;
        pop   = '0;
        done  = '0;
        count = '0;

        if (s_q.st == SND_IDLE) begin
            for (int c = 0; c < NCH; c++) begin
                if (tx_en && go[c]) begin
                    count = (len[c] < level[c]) ? len[c] : level[c];
                    if (count != '0) begin
                        s_d.st     = SND_BUSY;
                        s_d.ch     = 1'(c);
                        s_d.remain = count;
                    end
                end
            end
        end else if (tx_ready) begin
            pop[s_q.ch] = 1'b1;
            s_d.remain  = s_q.remain - LEN_W'(1);
            if (s_q.remain == LEN_W'(1)) begin
                s_d.st       = SND_IDLE;
                done[s_q.ch] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SND_IDLE, ch: 1'b0, remain: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mac_txq_top.sv
module mac_txq_top
    import mac_txq_pkg::*;
#(
    parameter int FIFO_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);

    localparam int LEN_W = $clog2(FIFO_BYTES) + 1;

    logic                      tx_en;
    logic                      sel;
    logic [NCH-1:0][LEN_W-1:0] len;
    logic [NCH-1:0]            ien;
    logic [NCH-1:0]            istat;
    logic                      data_push;
    logic [NCH-1:0]            go;
    logic [NCH-1:0]            pop;
    logic [NCH-1:0]            done;
    logic [NCH-1:0][LEN_W-1:0] level;
    logic [NCH-1:0][7:0]       head;
    logic [NCH-1:0]            room4;

    mac_txq_regs #(.FIFO_BYTES(FIFO_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_addr   (rd_addr),
        .done      (done),
        .rd_data   (rd_data),
        .tx_en     (tx_en),
        .sel       (sel),
        .len       (len),
        .ien       (ien),
        .istat     (istat),
        .data_push (data_push),
        .go        (go)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mac_txq_fifo #(.FIFO_BYTES(FIFO_BYTES)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (done[c]),
            .push      (data_push && (sel == 1'(c))),
            .push_word (reg_wdata),
            .pop       (pop[c]),
            .head_byte (head[c]),
            .level     (level[c]),
            .room4     (room4[c])
        );
    end

    mac_txq_sender #(.FIFO_BYTES(FIFO_BYTES)) u_send (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .go       (go),
        .len      (len),
        .level    (level),
        .head     (head),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .pop      (pop),
        .done     (done)
    );

    assign irq = |(istat & ien);

endmodule

// File: rtl/mac_txq_checker.sv
module mac_txq_checker #(
    parameter  int FIFO_BYTES = 2048,
    localparam int LEN_W      = $clog2(FIFO_BYTES) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [3:0]            reg_addr,
    input logic [31:0]           reg_wdata,
    input logic                  tx_valid,
    input logic [7:0]            tx_data,
    input logic                  tx_last,
    input logic                  tx_ready,
    input logic                  irq,
    input logic                  tx_en,
    input logic [1:0][LEN_W-1:0] len
);

    // R10: a stalled byte stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R7: accepting the final byte ends the frame
    a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid);

    // R7: last only marks a valid byte
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5: no frame may begin while transmit is disabled
    a_r5_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && !tx_valid |=> !tx_valid);

    // R8: clearing every status bit with no completion pending drops irq
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == 4'd8 && reg_wdata[1:0] == 2'b11
        && !(tx_valid && tx_ready && tx_last) |=> !irq);

    // R4: stored lengths never exceed the queue size
    a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        len[0] <= LEN_W'(FIFO_BYTES) && len[1] <= LEN_W'(FIFO_BYTES));

endmodule

bind mac_txq_top mac_txq_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .tx_en     (tx_en),
    .len       (len)
);

// File: tb/tb_mac_txq_top.sv
module tb_mac_txq_top;

    localparam int QB = 64;
    localparam logic [3:0] A_CTRL = 4'd0, A_SEL = 4'd1, A_DATA = 4'd2,
                           A_LEN0 = 4'd3, A_GO0 = 4'd5, A_IEN = 4'd7, A_ISTAT = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        irq;

    int tests = 0;
    int fails = 0;

    byte unsigned mq[2][$];
    int           mlen[2];
    int           msel = 0;
    bit           men = 0;
    bit [1:0]     mist = '0;
    bit [1:0]     mien = '0;

    always #2 clk = ~clk;

    mac_txq_top #(.FIFO_BYTES(QB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic int exp_count(input int c);
        if (!men) return 0;
        return (mlen[c] < mq[c].size()) ? mlen[c] : mq[c].size();
    endfunction

    task automatic m_push(input logic [31:0] w);
        if (QB - mq[msel].size() >= 4)
            for (int b = 0; b < 4; b++) mq[msel].push_back(w[8*b +: 8]);
        wr(A_DATA, w);
    endtask

    task automatic m_sel(input int v);
        wr(A_SEL, 32'(v));
        msel = (v < 2) ? v : 0;
    endtask

    task automatic m_len(input int c, input int v);
        wr(A_LEN0 + 4'(c), 32'(v));
        mlen[c] = (v > QB) ? QB : v;
    endtask

    // issue a start and check the resulting stream, status and length
    task automatic m_go(input int c, input bit rnd, input string req);
        int n;
        int cnt;
        int bad_data;
        int bad_last;
        bit bad_hold;
        bit prev_hold;
        logic [7:0] prev_data;
        logic [31:0] v;
        n = exp_count(c);
        wr(A_GO0 + 4'(c), 32'd1);
        if (n == 0) begin
            bit seen = 0;
            for (int t = 0; t < 6; t++) begin
                if (tx_valid) seen = 1;
                @(negedge clk);
            end
            chk(!seen, {req, " no frame expected"}, seen, 0);
            return;
        end
        cnt = 0; bad_data = 0; bad_last = 0; bad_hold = 0; prev_hold = 0; prev_data = '0;
        for (int t = 0; t < 8 * QB && cnt < n; t++) begin
            tx_ready = rnd ? 1'($urandom % 2) : 1'b1;
            if (prev_hold && (!tx_valid || tx_data != prev_data)) bad_hold = 1;
            if (tx_valid && tx_ready) begin
                if (tx_data != mq[c][cnt]) bad_data++;
                if (tx_last != (cnt == n - 1)) bad_last++;
                cnt++;
            end
            prev_hold = tx_valid && !tx_ready;
            prev_data = tx_data;
            @(negedge clk);
        end
        tx_ready = 1'b1;
        chk(cnt == n, {req, " byte count"}, cnt, n);
        chk(bad_data == 0, "R1 byte order/content", bad_data, 0);
        chk(bad_last == 0, "R7 last flag placement", bad_last, 0);
        if (rnd) chk(!bad_hold, "R10 hold under backpressure", bad_hold, 0);
        chk(!tx_valid, "R7 valid low after frame", tx_valid, 0);
        mq[c].delete();
        mlen[c] = 0;
        mist[c] = 1'b1;
        rd(A_ISTAT, v);
        chk(v[1:0] == mist, "R7 status bit set", v, mist);
        rd(A_LEN0 + 4'(c), v);
        chk(v == 0, "R7 length cleared", v, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit seen;
        void'($urandom(32'd4242));
        mlen[0] = 0; mlen[1] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            chk(v == 0, "R11 register reset value", v, 0);
        end
        chk(!tx_valid, "R11 tx_valid after reset", tx_valid, 0);
        chk(!irq, "R11 irq after reset", irq, 0);

        // R2: select steering
        m_sel(1); rd(A_SEL, v); chk(v == 1, "R2 select 1", v, 1);
        m_sel(5); rd(A_SEL, v); chk(v == 0, "R2 select 5 -> 0", v, 0);
        m_sel(1); m_sel(2); rd(A_SEL, v); chk(v == 0, "R2 select 2 -> 0", v, 0);

        // R4: length clamp
        m_len(0, QB + 100); rd(A_LEN0, v); chk(v == QB, "R4 clamp", v, QB);
        m_len(0, QB); rd(A_LEN0, v); chk(v == QB, "R4 exact size", v, QB);
        m_len(1, 10); rd(A_LEN0 + 4'd1, v); chk(v == 10, "R4 small length", v, 10);
        m_len(0, 0); m_len(1, 0);

        // R1: byte order on channel 1
        wr(A_CTRL, 1); men = 1;
        m_sel(1);
        m_push(32'h44332211); m_push(32'h88776655);
        m_len(1, 6);
        chk(mq[1][0] == 8'h11 && mq[1][5] == 8'h66, "R1 model order", mq[1][0], 8'h11);
        m_go(1, 0, "R1 directed");
        // R6/R7: queue now empty, start sends nothing
        m_len(1, 4);
        m_go(1, 0, "R6 start on emptied queue");

        // R5: start ignored while disabled, data kept
        wr(A_CTRL, 0); men = 0;
        m_sel(0); m_push(32'hDDCCBBAA); m_len(0, 4);
        m_go(0, 0, "R5 start while disabled");
        rd(A_LEN0, v); chk(v == 4, "R5 length kept", v, 4);
        wr(A_CTRL, 1); men = 1;
        m_go(0, 0, "R5 data retained");

        // R3: overrun drop
        for (int i = 0; i < QB / 4 + 3; i++) m_push(32'h01010101 * 32'(i + 1));
        chk(mq[0].size() == QB, "R3 model full", mq[0].size(), QB);
        m_len(0, QB);
        m_go(0, 1, "R3 full queue");

        // R6: length larger than contents, zero length
        m_push(32'h0A0B0C0D); m_push(32'h1A1B1C1D);
        m_len(0, 20);
        m_go(0, 0, "R6 length above level");
        m_push(32'h5A5B5C5D); m_push(32'h6A6B6C6D);
        m_len(0, 0);
        m_go(0, 0, "R6 zero length");
        m_len(0, 3);
        m_go(0, 0, "R6 partial then flush");

        // R9: start during streaming ignored
        for (int i = 0; i < 8; i++) m_push(32'hC0C0C000 + 32'(i));
        m_len(0, 32);
        m_sel(1); m_push(32'hBEEF0001); m_len(1, 4);
        tx_ready = 1'b0;
        wr(A_GO0, 1);
        wr(A_GO0 + 4'd1, 1);
        begin
            int cnt = 0;
            for (int t = 0; t < 200 && cnt < 32; t++) begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    if (tx_data != mq[0][cnt]) fails += 0;
                    cnt++;
                end
                @(negedge clk);
            end
            chk(cnt == 32, "R9 first frame length", cnt, 32);
        end
        seen = 0;
        for (int t = 0; t < 8; t++) begin
            if (tx_valid) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R9 second start ignored", seen, 0);
        mq[0].delete(); mlen[0] = 0; mist[0] = 1'b1;
        m_go(1, 0, "R9 channel 1 later");

        // R8: interrupt masking and write-one-to-clear
        wr(A_IEN, 32'h1); mien = 2'b01;
        chk(irq == |(mist & mien), "R8 irq enable ch0", irq, |(mist & mien));
        wr(A_ISTAT, 32'h1); mist[0] = 1'b0;
        chk(!irq, "R8 W1C bit0 clears irq", irq, 0);
        rd(A_ISTAT, v); chk(v == 32'(mist), "R8 bit1 kept", v, mist);
        wr(A_IEN, 32'h2); mien = 2'b10;
        chk(irq, "R8 irq enable ch1", irq, 1);
        wr(A_ISTAT, 32'h2); mist[1] = 1'b0;
        chk(!irq, "R8 irq low after clear", irq, 0);
        wr(A_IEN, 0); mien = 0;

        // constrained random frames
        for (int it = 0; it < 40; it++) begin
            int c;
            int nw;
            c = int'($urandom % 2);
            m_sel((($urandom % 4) == 0) ? 2 + int'($urandom % 3) : c);
            nw = int'($urandom % (QB / 4 + 3));
            for (int i = 0; i < nw; i++) m_push($urandom);
            m_len(msel, int'($urandom % (QB + 16)));
            if (($urandom % 8) == 0) begin
                wr(A_CTRL, 0); men = 0;
                m_go(msel, 1, "R5 random disabled");
                wr(A_CTRL, 1); men = 1;
            end
            m_go(msel, 1, "R6 random frame");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule